// File: doc/BRIEF.md
# Write Retire Hazard Guard

This block sits in front of the command issue port of a channel that carries several packet-based DRAM devices. Each device has one write buffer. A write parks its data in that buffer. The data is retired into the memory array later, at the device's own pace. The guard keeps a small record for each device: whether the buffer still holds unretired data, which bank that data belongs to, how many slots have passed since the last write, and whether a second write landed while an older one was still unretired. One command slot is one clock cycle.

Each slot, the proposer offers one command with a valid/ready handshake. The guard decides in the same cycle what to do with it. It passes the command to the issue port unchanged. It swaps in a no-operation column command and holds the read back one slot. Or it stalls the command, leaving the issue slot idle. The rules it enforces are these:

- A queued buffer must not be overwritten by a read.
- A bank whose row would receive pending write data must not be precharged.
- No more than two devices may hold unretired data at once.

Top module: `write_retire_guard`

## Requirements
- R1: Condition for a read hazard: a device took a write while an earlier write of its own was still unretired, and a read to that device is offered exactly HAZ_GAP slots (default 3) after that second write. In that slot the guard issues the NOCOP code (0) to that device with `cmd_ready` low. The read is accepted unchanged in the following slot.
- R2: A precharge (code 3) to a device whose buffer is unretired and whose recorded bank equals `cmd_bank` is stalled: `cmd_ready` is low and `iss_valid` is low. A precharge to any other bank of that device passes.
- R3: In a slot that issues a write (code 2) to one device, every other device whose last write is at least RTR_SLOTS slots old (default 3) is retired. A device written fewer than RTR_SLOTS slots earlier stays unretired.
- R4: An unretired buffer retires in the first slot at least RTR_SLOTS after its last write that does not issue a read (code 1) to the same device. Reads to that device keep it unretired for as long as they continue.
- R5: Only one case can leave three devices unretired after the slot: a write to a device with no unretired data while two other devices hold data younger than RTR_SLOTS. Such a write is stalled (`cmd_ready` low, `iss_valid` low), so at most two devices ever hold unretired data.
- R6: A command that is not stalled or substituted is accepted (`cmd_ready` high) and appears on the issue port in the same cycle with its opcode, device and bank unchanged. The opcode codes are NOCOP=0, RD=1, WR=2, PRER=3.
- R7: After reset, no device holds unretired data and `cmd_ready` is high. With `cmd_valid` low, `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, one command slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A proposed command is present |
| cmd_ready | output | 1 | The proposed command is consumed this slot |
| cmd_op | input | 2 | Proposed opcode (0 NOCOP, 1 RD, 2 WR, 3 PRER) |
| cmd_dev | input | DEV_W | Proposed target device |
| cmd_bank | input | BANK_W | Proposed target bank |
| iss_valid | output | 1 | A command is issued this slot |
| iss_op | output | 2 | Issued opcode, possibly a substituted NOCOP |
| iss_dev | output | DEV_W | Issued target device |
| iss_bank | output | BANK_W | Issued target bank |

## Verification
Every decision is combinational, so `cmd_ready` and the issue port answer the offered command in the same cycle. The bench drives each command after a falling edge and compares one time unit later, well before the next rising edge. Retire state changes at the rising edge that closes the slot, so its effect shows up only in the decision for the next offered command. The bench's model updates at that same edge. Slot ages count from the write slot: a read in the third slot after a write sees age 3. The directed sequences place reads, writes and precharges at those exact ages. Random traffic then holds any unaccepted command until it is consumed, as the handshake requires.

// File: rtl/write_retire_guard.sv
module write_retire_guard #(
  parameter int NUM_DEV   = 4,
  parameter int BANK_W    = 4,
  parameter int RTR_SLOTS = 3,
  parameter int HAZ_GAP   = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [1:0]                     cmd_op,
  input  logic [$clog2(NUM_DEV)-1:0]     cmd_dev,
  input  logic [BANK_W-1:0]              cmd_bank,
  output logic                           iss_valid,
  output logic [1:0]                     iss_op,
  output logic [$clog2(NUM_DEV)-1:0]     iss_dev,
  output logic [BANK_W-1:0]              iss_bank
);
  localparam int DEV_W   = $clog2(NUM_DEV);
  localparam int AGE_MAX = ((RTR_SLOTS > HAZ_GAP) ? RTR_SLOTS : HAZ_GAP) + 1;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);
  localparam int CNT_W   = $clog2(NUM_DEV + 1);
  localparam logic [1:0] OP_NOCOP = 2'd0;
  localparam logic [1:0] OP_RD    = 2'd1;
  localparam logic [1:0] OP_WR    = 2'd2;
  localparam logic [1:0] OP_PRER  = 2'd3;

  logic [NUM_DEV-1:0] pend_q, dbl_q;
  logic [BANK_W-1:0]  bank_q [NUM_DEV];
  logic [AGE_W-1:0]   age_q  [NUM_DEV];

  logic             rd_hazard, prer_block, wr_block, accepted;
  logic [CNT_W-1:0] young_others;

  always_comb begin
    young_others = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (pend_q[i] && (DEV_W'(i) != cmd_dev) && (int'(age_q[i]) < RTR_SLOTS))
        young_others = young_others + 1'b1;
  end

  assign rd_hazard  = cmd_valid && cmd_op == OP_RD && dbl_q[cmd_dev] &&
                      int'(age_q[cmd_dev]) == HAZ_GAP;
  assign prer_block = cmd_valid && cmd_op == OP_PRER && pend_q[cmd_dev] &&
                      bank_q[cmd_dev] == cmd_bank;
  assign wr_block   = cmd_valid && cmd_op == OP_WR && !pend_q[cmd_dev] &&
                      young_others >= CNT_W'(2);

  assign cmd_ready = !(rd_hazard || prer_block || wr_block);
  assign iss_valid = cmd_valid && !(prer_block || wr_block);
  assign iss_op    = rd_hazard ? OP_NOCOP : cmd_op;
  assign iss_dev   = cmd_dev;
  assign iss_bank  = cmd_bank;
  assign accepted  = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      dbl_q  <= '0;
      for (int i = 0; i < NUM_DEV; i++) begin
        bank_q[i] <= '0;
        age_q[i]  <= AGE_W'(AGE_MAX);
      end
    end else begin
      for (int i = 0; i < NUM_DEV; i++) begin
        if (accepted && cmd_op == OP_WR && cmd_dev == DEV_W'(i)) begin
          pend_q[i] <= 1'b1;
          dbl_q[i]  <= pend_q[i];
          bank_q[i] <= cmd_bank;
          age_q[i]  <= AGE_W'(1);
        end else begin
          if (int'(age_q[i]) < AGE_MAX)
            age_q[i] <= age_q[i] + 1'b1;
          if (pend_q[i] && int'(age_q[i]) >= RTR_SLOTS &&
              !(accepted && cmd_op == OP_RD && cmd_dev == DEV_W'(i))) begin
            pend_q[i] <= 1'b0;
            dbl_q[i]  <= 1'b0;
          end
        end
      end
    end
  end

  p_max_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pend_q) <= 2);

  p_no_prer_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op == OP_PRER) |-> !(pend_q[iss_dev] && bank_q[iss_dev] == iss_bank));

  p_nocop_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_RD && iss_op == OP_NOCOP) |-> (!cmd_ready && iss_valid));

  p_pass_through_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |-> (iss_valid && iss_op == cmd_op));

  p_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op == OP_RD && pend_q[iss_dev]) |=> pend_q[$past(iss_dev)]);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> !iss_valid);
endmodule

// File: tb/tb_write_retire_guard.sv
module tb_write_retire_guard;
  localparam int ND  = 4;
  localparam int BW  = 4;
  localparam int RTR = 3;
  localparam int HAZ = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0;
  logic [1:0] cmd_op = 0;
  logic [1:0] cmd_dev = 0;
  logic [BW-1:0] cmd_bank = 0;
  logic cmd_ready, iss_valid;
  logic [1:0] iss_op, iss_dev;
  logic [BW-1:0] iss_bank;

  write_retire_guard #(.NUM_DEV(ND), .BANK_W(BW), .RTR_SLOTS(RTR), .HAZ_GAP(HAZ)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_dev(cmd_dev), .cmd_bank(cmd_bank), .iss_valid(iss_valid),
    .iss_op(iss_op), .iss_dev(iss_dev), .iss_bank(iss_bank));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_pend [ND];
  bit m_dbl  [ND];
  int m_bank [ND];
  int m_age  [ND];

  // 0 pass, 1 nocop, 2 stall
  function automatic int decide(bit v, int op, int dv, int bk);
    int young = 0;
    if (!v) return 0;
    for (int i = 0; i < ND; i++)
      if (m_pend[i] && i != dv && m_age[i] < RTR) young++;
    if (op == 1 && m_dbl[dv] && m_age[dv] == HAZ) return 1;
    if (op == 3 && m_pend[dv] && m_bank[dv] == bk) return 2;
    if (op == 2 && !m_pend[dv] && young >= 2) return 2;
    return 0;
  endfunction

  function automatic string tag_of(int d, int op);
    if (d == 1) return "R1";
    if (d == 2) return (op == 3) ? "R2" : "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit acc, int op, int dv, int bk);
    for (int i = 0; i < ND; i++) begin
      if (acc && op == 2 && dv == i) begin
        m_dbl[i] = m_pend[i]; m_pend[i] = 1; m_bank[i] = bk; m_age[i] = 1;
      end else begin
        if (m_pend[i] && m_age[i] >= RTR && !(acc && op == 1 && dv == i)) begin
          m_pend[i] = 0; m_dbl[i] = 0;
        end
        if (m_age[i] < 100) m_age[i]++;
      end
    end
  endtask

  // want: -1 use model only, else required decision (also cross-checks the model)
  task automatic step(bit v, int op, int dv, int bk, int want, string req, output bit acc);
    int d; int e_op; bit e_rdy, e_iv;
    @(negedge clk);
    cmd_valid = v; cmd_op = 2'(op); cmd_dev = 2'(dv); cmd_bank = BW'(bk);
    #1;
    d = decide(v, op, dv, bk);
    if (want >= 0) check(d == want, req, "bench sequence decision", d, want);
    if (req == "") req = tag_of(d, op);
    e_rdy = (d == 0);
    e_iv  = v && (d != 2);
    e_op  = (d == 1) ? 0 : op;
    check(cmd_ready == e_rdy, req, "cmd_ready", cmd_ready, e_rdy);
    check(iss_valid == e_iv, req, "iss_valid", iss_valid, e_iv);
    if (e_iv) begin
      check(iss_op == 2'(e_op), req, "iss_op", iss_op, e_op);
      check(iss_dev == 2'(dv) && iss_bank == BW'(bk), req, "iss_dev/bank",
            {iss_dev, iss_bank}, {dv[1:0], bk[BW-1:0]});
    end
    acc = v && e_rdy;
    @(posedge clk);
    model_step(acc, op, dv, bk);
  endtask

  task automatic idle(int n);
    bit a;
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, "R7", a);
  endtask

  initial begin
    bit a;
    int op, dv, bk;
    bit hold;
    for (int i = 0; i < ND; i++) begin
      m_pend[i] = 0; m_dbl[i] = 0; m_bank[i] = 0; m_age[i] = 100;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 check(cmd_ready == 1 && iss_valid == 0, "R7", "reset ready/valid",
             {cmd_ready, iss_valid}, 2'b10);
    idle(2);

    // R1: double write then read at the hazard gap
    step(1, 2, 1, 0, 0, "R6", a);
    step(1, 2, 1, 1, 0, "R6", a);
    step(1, 1, 1, 0, 0, "R4", a);
    step(1, 1, 1, 0, 0, "R4", a);
    step(1, 1, 1, 0, 1, "R1", a);
    check(a == 0, "R1", "read held at hazard slot", a, 0);
    step(1, 1, 1, 0, 0, "R1", a);
    check(a == 1, "R1", "read accepted next slot", a, 1);
    idle(5);

    // R4 + R2: reads hold the buffer, precharge of that bank is stalled
    step(1, 2, 2, 5, 0, "R6", a);
    for (int k = 0; k < 5; k++) step(1, 1, 2, 0, 0, "R4", a);
    step(1, 3, 2, 5, 2, "R4", a);
    step(1, 3, 2, 6, 0, "R2", a);
    step(1, 3, 2, 5, 0, "R2", a);
    idle(5);

    // R3: cross-device retire only for old writes
    step(1, 2, 0, 3, 0, "R6", a);
    for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 0, "R4", a);
    step(1, 2, 3, 0, 0, "R3", a);
    step(1, 3, 0, 3, 0, "R3", a);
    step(1, 2, 1, 7, 0, "R3", a);
    step(1, 3, 3, 0, 2, "R3", a);
    idle(5);

    // R5: third device write stalled while two young buffers exist
    step(1, 2, 0, 1, 0, "R6", a);
    step(1, 2, 1, 1, 0, "R6", a);
    step(1, 2, 2, 1, 2, "R5", a);
    step(1, 2, 2, 1, 0, "R5", a);
    idle(5);

    // constrained random traffic with handshake hold
    process::self().srandom(32'h5eed);
    hold = 0; op = 0; dv = 0; bk = 0;
    for (int n = 0; n < 4000; n++) begin
      bit v;
      if (!hold) begin
        int r = $urandom_range(0, 9);
        op = (r < 4) ? 1 : (r < 7) ? 2 : (r < 9) ? 3 : 0;
        dv = $urandom_range(0, ND - 1);
        bk = $urandom_range(0, 3);
        v  = ($urandom_range(0, 7) != 0);
      end else v = 1;
      step(v, op, dv, bk, -1, "", a);
      hold = v && !a;
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule